// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a cache and main memory. Stores from a write-through cache, and dirty victims pushed out by a write-back refill, are parked in a small queue of pending memory writes. Read misses are allowed to go ahead of that queue. Before a miss goes out, its address is checked against every parked entry. If nothing matches, the read takes the memory port at once and does not wait for the queue to empty. If something matches, the newest matching entry's data is returned directly, so the read never sees a stale memory value.

When a miss also evicts a dirty block, the victim is placed in the queue in the same cycle that the miss is accepted. The refill read then goes to memory first, the cache gets its data back, and only after that is the victim written out. Queued writes leave for memory in arrival order whenever no read is in flight.

Back-pressure rules. The write port and the read-miss port use valid/ready handshakes, and a transfer happens on a clock edge where both are high. The read response is a one-cycle `rsp_valid` pulse that cannot be stalled. On the memory side, a request is taken on an edge where `mem_req_valid` and `mem_req_ready` are both high. A write request that has not been taken may be replaced by a read, because reads have priority. A read request, once presented, holds still until it is taken. Memory read data comes back later as a `mem_rsp_valid` pulse.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty, `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The queue holds four entries. When all four are occupied, `wr_ready` is 0 and an offered write waits until an entry drains.
- R3: Queued writes are issued to memory with `mem_req_we`=1 in the order in which they were accepted, each carrying its own address and data.
- R4: A read miss whose address matches no queued entry is presented on the memory port with `mem_req_we`=0 in the cycle after it is accepted. It is taken before any queued write, even when writes are waiting.
- R5: A read miss whose address matches a queued entry gets the data of the youngest matching entry. `rsp_valid` is high in the cycle right after acceptance, and no memory read is issued.
- R6: For a read served by memory, `rsp_valid` rises in the cycle after `mem_rsp_valid` and carries `mem_rsp_data`.
- R7: A read with `rd_victim`=1 queues the victim address and data when it is accepted, and it is accepted only if a slot is free. The refill read reaches memory and responds before the victim write is issued.
- R8: While a read is in flight, `rd_ready` is 0, and writes can still be queued.
- R9: An untaken memory read request keeps `mem_req_valid`=1, `mem_req_we`=0 and a stable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered by the cache |
| wr_ready | output | 1 | Write can be queued this cycle |
| wr_addr | input | ADDR_W | Write block address |
| wr_data | input | DATA_W | Write block data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss can be accepted |
| rd_addr | input | ADDR_W | Read miss address |
| rd_victim | input | 1 | Read replaces a dirty block |
| rd_victim_addr | input | ADDR_W | Victim block address |
| rd_victim_data | input | DATA_W | Victim block data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | DATA_W | Read response data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data pulse |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
A forwarded read answers zero cycles after the edge that accepts it: `rsp_valid` is already high at the next falling edge. A memory read appears on the port in the cycle after acceptance, and its response comes one cycle after `mem_rsp_valid`. The bench drives inputs just after rising edges and samples at falling edges. It records the cycle of every handshake and of every memory response pulse, and compares each response against that exact cycle count, never against an open window. Memory traffic is logged at the falling edge before each taking edge, so ordering checks read that log.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE     = 2'd0,
    RD_MEM_REQ  = 2'd1,
    RD_MEM_WAIT = 2'd2,
    RD_RESP     = 2'd3
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop,
  output logic [DEPTH-1:0]               slot_vld,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
  output logic [PTR_W-1:0]               head,
  output logic [ADDR_W-1:0]              head_addr,
  output logic [DATA_W-1:0]              head_data,
  output logic [CNT_W-1:0]               occ,
  output logic                           full,
  output logic                           empty
);
  logic [PTR_W-1:0] tail;

  // ring pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      occ <= occ + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // one register set per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[i] <= 1'b0;
      end else if (push && tail == PTR_W'(i)) begin
        slot_vld[i] <= 1'b1;
      end else if (pop && head == PTR_W'(i)) begin
        slot_vld[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (push && tail == PTR_W'(i)) begin
        slot_addr[i] <= push_addr;
        slot_data[i] <= push_data;
      end
    end
  end

  assign head_addr = slot_addr[head];
  assign head_data = slot_data[head];
  assign full      = (occ == CNT_W'(DEPTH));
  assign empty     = (occ == '0);
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             slot_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
  input  logic [PTR_W-1:0]             head,
  input  logic [ADDR_W-1:0]            q_addr,
  output logic                         hit,
  output logic [DATA_W-1:0]            hit_data
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = slot_vld[i] && (slot_addr[i] == q_addr);
  end

  // walk oldest to youngest; a later (younger) match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] idx;
      idx = head + PTR_W'(k);
      if (eq[idx]) begin
        hit      = 1'b1;
        hit_data = slot_data[idx];
      end
    end
  end
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_victim,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_fire,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              wr_fire,
  input  logic              full,
  input  logic              empty,
  input  logic              hit,
  input  logic [DATA_W-1:0] hit_data,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  rd_state_e         state;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              drain;

  assign rd_ready = (state == RD_IDLE) && (!rd_victim || !full);
  assign rd_fire  = rd_valid && rd_ready;
  // a victim push owns the single enqueue slot in its cycle
  assign wr_ready = !full && !(rd_fire && rd_victim);
  assign wr_fire  = wr_valid && wr_ready;

  // writes may use the port only when no read is being taken or in flight
  assign drain         = (state == RD_IDLE) && !rd_fire && !empty;
  assign mem_req_valid = (state == RD_MEM_REQ) || drain;
  assign mem_req_we    = (state != RD_MEM_REQ);
  assign mem_req_addr  = (state == RD_MEM_REQ) ? rd_addr_q : head_addr;
  assign mem_req_wdata = head_data;
  assign pop           = drain && mem_req_ready;

  assign rsp_valid = (state == RD_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RD_IDLE;
      rd_addr_q <= '0;
      rsp_data  <= '0;
    end else begin
      unique case (state)
        RD_IDLE: if (rd_fire) begin
          if (hit) begin
            rsp_data <= hit_data;
            state    <= RD_RESP;
          end else begin
            rd_addr_q <= rd_addr;
            state     <= RD_MEM_REQ;
          end
        end
        RD_MEM_REQ:  if (mem_req_ready) state <= RD_MEM_WAIT;
        RD_MEM_WAIT: if (mem_rsp_valid) begin
          rsp_data <= mem_rsp_data;
          state    <= RD_RESP;
        end
        RD_RESP:     state <= RD_IDLE;
        default:     state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_victim,
  input  logic [ADDR_W-1:0] rd_victim_addr,
  input  logic [DATA_W-1:0] rd_victim_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic [DEPTH-1:0]             slot_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [PTR_W-1:0]             head;
  logic [ADDR_W-1:0]            head_addr;
  logic [DATA_W-1:0]            head_data;
  logic [CNT_W-1:0]             occ;
  logic                         full, empty;
  logic                         hit;
  logic [DATA_W-1:0]            hit_data;
  logic                         rd_fire, wr_fire, pop;
  logic                         push;
  logic [ADDR_W-1:0]            push_addr;
  logic [DATA_W-1:0]            push_data;

  assign push      = wr_fire || (rd_fire && rd_victim);
  assign push_addr = (rd_fire && rd_victim) ? rd_victim_addr : wr_addr;
  assign push_data = (rd_fire && rd_victim) ? rd_victim_data : wr_data;

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .pop       (pop),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head      (head),
    .head_addr (head_addr),
    .head_data (head_data),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head      (head),
    .q_addr    (rd_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  wbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_victim     (rd_victim),
    .rd_addr       (rd_addr),
    .rd_ready      (rd_ready),
    .rd_fire       (rd_fire),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_fire       (wr_fire),
    .full          (full),
    .empty         (empty),
    .hit           (hit),
    .hit_data      (hit_data),
    .head_addr     (head_addr),
    .head_data     (head_data),
    .pop           (pop),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_victim,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [CNT_W-1:0]  occ
);
  // R2: a full queue refuses writes
  p_full_blocks_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !wr_ready);

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R4: a write never uses the port in a cycle where a read is being accepted
  p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> !(rd_valid && rd_ready));

  // R9: an untaken read request holds still
  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && !mem_req_ready) |=>
      (mem_req_valid && !mem_req_we && $stable(mem_req_addr)));

  // R5: the response is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: no new read while a response is being delivered
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rd_ready);

  // R7: a victim-carrying read is only taken with a free slot
  p_victim_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_victim) |-> (occ < CNT_W'(DEPTH)));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_victim     (rd_victim),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .occ           (occ)
);

// File: tb/wbuf_bypass_tb.sv
`timescale 1ns/1ps
module wbuf_bypass_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_victim = 1'b0;
  logic [AW-1:0] rd_victim_addr = '0;
  logic [DW-1:0] rd_victim_data = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rsp_cyc = -100;
  bit finished = 1'b0;

  // memory traffic log
  int            log_n = 0;
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wbuf_bypass u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_victim(rd_victim), .rd_victim_addr(rd_victim_addr), .rd_victim_data(rd_victim_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    return {a, a ^ 16'h5A5A};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // log every handshake at the falling edge before the edge that takes it
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready && log_n < 64) begin
      log_we[log_n]   = mem_req_we;
      log_addr[log_n] = mem_req_addr;
      log_data[log_n] = mem_req_wdata;
      log_n = log_n + 1;
    end
  end

  // memory read responder: data pulse three edges after the taking edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_req_ready && !mem_req_we) begin
        logic [AW-1:0] a;
        a = mem_req_addr;
        @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memfn(a);
        rsp_cyc = cyc;
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    while (!wr_ready && n < 200) begin @(negedge clk); n++; end
    check(wr_ready, "R2 write accept", DW'(wr_ready), 1);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  int acc_cyc;
  task automatic rd_issue(input logic [AW-1:0] a, input bit vic,
                          input logic [AW-1:0] va, input logic [DW-1:0] vd);
    int n = 0;
    rd_valid = 1'b1; rd_addr = a; rd_victim = vic;
    rd_victim_addr = va; rd_victim_data = vd;
    @(negedge clk);
    while (!rd_ready && n < 200) begin @(negedge clk); n++; end
    check(rd_ready, "R8 read accept", DW'(rd_ready), 1);
    @(posedge clk); #1;
    acc_cyc = cyc;
    rd_valid = 1'b0; rd_victim = 1'b0;
  endtask

  int got_cyc;
  task automatic rd_wait(input logic [DW-1:0] exp, input bit fwd, input string tag);
    int n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    got_cyc = cyc;
    check(rsp_valid, {tag, " response arrives"}, DW'(rsp_valid), 1);
    check(rsp_data == exp, {tag, " response data"}, rsp_data, exp);
    if (fwd)
      check(got_cyc == acc_cyc, "R5 forward latency", DW'(got_cyc - acc_cyc), 0);
    else
      check(got_cyc == rsp_cyc + 1, "R6 response one cycle after memory",
            DW'(got_cyc - rsp_cyc), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(wr_ready == 1'b1, "R1 wr_ready", DW'(wr_ready), 1);
    check(rd_ready == 1'b1, "R1 rd_ready", DW'(rd_ready), 1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", DW'(mem_req_valid), 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", DW'(rsp_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_fill_drain;
    int s = log_n;
    mem_req_ready = 1'b0;
    for (int i = 0; i < 4; i++) push(AW'(16'h0010 + i), DW'(32'hA000_0000 + i));
    @(negedge clk);
    check(wr_ready == 1'b0, "R2 full stalls writes", DW'(wr_ready), 0);
    @(posedge clk); #1;
    fork
      push(16'h0014, 32'hA000_0004);
      begin idle(3); mem_req_ready = 1'b1; end
    join
    idle(12);
    check(log_n - s == 5, "R3 five writes drained", DW'(log_n - s), 5);
    for (int i = 0; i < 5; i++) begin
      check(log_we[s+i] && log_addr[s+i] == AW'(16'h0010 + i) &&
            log_data[s+i] == DW'(32'hA000_0000 + i),
            "R3 drain order", {log_addr[s+i], log_data[s+i][15:0]},
            {AW'(16'h0010 + i), 16'(i)});
    end
  endtask

  task automatic t_bypass;
    int s = log_n;
    mem_req_ready = 1'b0;
    push(16'h0100, 32'h1111_0000);
    push(16'h0101, 32'h1111_0001);
    rd_issue(16'h0300, 1'b0, '0, '0);
    @(negedge clk);
    check(mem_req_valid && !mem_req_we && mem_req_addr == 16'h0300,
          "R4 read presented ahead of writes", DW'(mem_req_addr), 32'h0300);
    check(rd_ready == 1'b0, "R8 busy during read", DW'(rd_ready), 0);
    @(posedge clk); #1;
    push(16'h0102, 32'h1111_0002);   // R8 writes still queue
    idle(2);
    @(negedge clk);
    check(mem_req_valid && !mem_req_we && mem_req_addr == 16'h0300,
          "R9 read request held", DW'(mem_req_addr), 32'h0300);
    @(posedge clk); #1;
    mem_req_ready = 1'b1;
    rd_wait(memfn(16'h0300), 1'b0, "R6");
    idle(10);
    check(log_n - s == 4, "R4 one read then three writes", DW'(log_n - s), 4);
    check(!log_we[s] && log_addr[s] == 16'h0300, "R4 read went first",
          DW'(log_addr[s]), 32'h0300);
    check(log_we[s+3] && log_addr[s+3] == 16'h0102, "R3 late write drained last",
          DW'(log_addr[s+3]), 32'h0102);
  endtask

  task automatic t_forward;
    int s = log_n;
    mem_req_ready = 1'b0;
    push(16'h0040, 32'h0000_0D01);
    push(16'h0080, 32'h0000_0D02);
    push(16'h0040, 32'h0000_0D03);
    rd_issue(16'h0040, 1'b0, '0, '0);
    rd_wait(32'h0000_0D03, 1'b1, "R5 youngest");
    idle(1);
    rd_issue(16'h0080, 1'b0, '0, '0);
    rd_wait(32'h0000_0D02, 1'b1, "R5 single match");
    @(posedge clk); #1;
    mem_req_ready = 1'b1;
    idle(10);
    check(log_n - s == 3, "R5 no memory read on forward", DW'(log_n - s), 3);
    for (int i = 0; i < 3; i++)
      check(log_we[s+i] == 1'b1, "R5 only writes on port", DW'(log_we[s+i]), 1);
  endtask

  task automatic t_victim;
    int s = log_n;
    int vw = 0;
    mem_req_ready = 1'b1;
    rd_issue(16'h0500, 1'b1, 16'h0600, 32'hDEAD_BEEF);
    rd_wait(memfn(16'h0500), 1'b0, "R7 refill");
    for (int i = s; i < log_n; i++) if (log_we[i]) vw++;
    check(vw == 0, "R7 victim not written before response", DW'(vw), 0);
    idle(8);
    check(!log_we[s] && log_addr[s] == 16'h0500, "R7 refill read first",
          DW'(log_addr[s]), 32'h0500);
    check(log_we[s+1] && log_addr[s+1] == 16'h0600 && log_data[s+1] == 32'hDEAD_BEEF,
          "R7 victim written after", log_data[s+1], 32'hDEAD_BEEF);
  endtask

  task automatic t_victim_full;
    int s;
    mem_req_ready = 1'b0;
    for (int i = 0; i < 4; i++) push(AW'(16'h0700 + i), DW'(32'hC000_0000 + i));
    s = log_n;
    rd_valid = 1'b1; rd_addr = 16'h0800; rd_victim = 1'b1;
    rd_victim_addr = 16'h0900; rd_victim_data = 32'h0000_0999;
    @(negedge clk);
    check(rd_ready == 1'b0, "R7 victim read stalls when full", DW'(rd_ready), 0);
    @(posedge clk); #1;
    mem_req_ready = 1'b1;
    rd_issue(16'h0800, 1'b1, 16'h0900, 32'h0000_0999);
    rd_wait(memfn(16'h0800), 1'b0, "R6 after stall");
    idle(12);
    check(log_we[s] && log_addr[s] == 16'h0700, "R3 one drain frees a slot",
          DW'(log_addr[s]), 32'h0700);
    check(!log_we[s+1] && log_addr[s+1] == 16'h0800, "R4 read before remaining writes",
          DW'(log_addr[s+1]), 32'h0800);
    check(log_n - s == 6, "R7 victim eventually written", DW'(log_n - s), 6);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_fill_drain;
    t_bypass;
    t_forward;
    t_victim;
    t_victim_full;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule